// File: doc/BRIEF.md
# Dynamic Sharer Vector Encoder

This block maintains the compact sharer field of a directory entry for a machine of up to 512 nodes. The field is 64 bits wide and has two layouts. The exact layout holds one bit per node inside a single 64-node octant, and a 3-bit octant number tags it. The coarse layout holds one bit per group of 8 consecutive nodes across the whole machine. A combinational add path takes the present field, its layout flag and octant tag, plus one new sharer ID, and returns the updated field. When the new sharer lies outside the tagged octant, the field moves to the coarse layout and every existing sharer is kept.

A sequential expander takes a field and turns it into a stream of single node IDs, one per clock, for the invalidation unicasts. A coarse bit expands to all eight members of its group. Invalidating a node that never held the line is harmless. Small configurations keep 16-bit entries in storage. A pair of combinational converters widens such an entry to the internal exact form on read and trims the internal vector back to 16 bits on write.

Top module: `sharer_vec_codec`

## Requirements
- R1: Adding a node whose ID bits [8:6] equal the octant tag of a non-empty exact field sets vector bit ID[5:0]. The field stays exact (coarse flag 0) and the tag is unchanged.
- R2: Adding a node to an exact field whose vector is all zero yields an exact field. Its tag is ID[8:6] and only bit ID[5:0] is set.
- R3: Adding a node from another octant to a non-empty exact field sets the coarse flag to 1. Each old sharer at bit i sets coarse bit {tag, i[5:3]}, and the new node sets coarse bit ID[8:3]. The coarse bits cover every old sharer.
- R4: Adding a node to a coarse field sets bit ID[8:3]. All other bits are kept and the field stays coarse.
- R5: Widening a 16-bit entry gives an exact field with tag 0, the entry in bits [15:0] and zeros above. Narrowing returns bits [15:0] of the internal vector.
- R6: After a start on an exact field, one node ID per cycle is presented with valid high, in ascending order. Each ID is {tag, bit index}, and the first one appears in the cycle after the start edge.
- R7: After a start on a coarse field, each set bit j yields the eight IDs 8j to 8j+7, one per cycle. The whole stream is in ascending order.
- R8: Busy is high for exactly the cycles in which IDs are presented. Done is a one-cycle pulse in the cycle after the last ID, with busy low.
- R9: A start with an all-zero vector produces no valid ID. Done is high in the cycle after the start edge.
- R10: A start raised while busy is ignored, and the stream in progress continues unchanged.
- R11: During reset, busy, valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_vec_i | input | 64 | Present sharer vector for the add path |
| enc_coarse_i | input | 1 | Present layout: 1 coarse, 0 exact |
| enc_oct_i | input | 3 | Present octant tag |
| enc_node_i | input | 9 | Node ID to add |
| enc_vec_o | output | 64 | Updated sharer vector |
| enc_coarse_o | output | 1 | Updated layout flag |
| enc_oct_o | output | 3 | Updated octant tag |
| nar_entry_i | input | 16 | Stored 16-bit entry to widen |
| wide_vec_o | output | 64 | Widened vector |
| wide_coarse_o | output | 1 | Widened layout flag (always exact) |
| wide_oct_o | output | 3 | Widened octant tag (always 0) |
| wide_vec_i | input | 64 | Internal vector to narrow |
| nar_entry_o | output | 16 | Narrowed 16-bit entry |
| inv_start_i | input | 1 | Start expansion of a field |
| inv_vec_i | input | 64 | Field vector to expand |
| inv_coarse_i | input | 1 | Layout of field to expand |
| inv_oct_i | input | 3 | Octant tag of field to expand |
| inv_busy_o | output | 1 | Expansion in progress |
| inv_valid_o | output | 1 | inv_node_o carries an ID |
| inv_node_o | output | 9 | Node ID to invalidate |
| inv_done_o | output | 1 | One-cycle end-of-expansion pulse |

## Verification
The assertions on the add path assume the input field is well formed. A coarse field may carry any tag, but an exact field is read through its tag only. The add-path stimulus supplies only such fields. The expander assertions assume that start is a level sampled at a clock edge and that the field inputs are steady at that edge. The bench drives every input on the falling edge, so both assumptions hold. It also raises start during busy streams on purpose, to show that the running job is not disturbed.

// File: rtl/shv_pkg.sv
package shv_pkg;
  localparam int NODES  = 512;
  localparam int VEC_W  = 64;
  localparam int NODE_W = $clog2(NODES);
  localparam int LOC_W  = $clog2(VEC_W);
  localparam int OCT_W  = NODE_W - LOC_W;
  localparam int GRP_W  = $clog2(NODES / VEC_W);

  typedef logic [VEC_W-1:0]  vec_t;
  typedef logic [NODE_W-1:0] node_t;
  typedef logic [OCT_W-1:0]  oct_t;
  typedef logic [LOC_W-1:0]  idx_t;
  typedef logic [GRP_W-1:0]  sub_t;

  // index of the lowest set bit (0 when the vector is empty)
  function automatic idx_t low_idx(input vec_t v);
    idx_t r = '0;
    for (int i = VEC_W - 1; i >= 0; i--)
      if (v[i]) r = idx_t'(i);
    return r;
  endfunction

  // exact vector inside octant o folded to one bit per 8-node group
  function automatic vec_t fold_coarse(input vec_t v, input oct_t o);
    vec_t r = '0;
    for (int i = 0; i < VEC_W; i++) begin
      idx_t pos = idx_t'(i);
      if (v[i]) r[{o, pos[LOC_W-1:GRP_W]}] = 1'b1;
    end
    return r;
  endfunction

  // does a field include node n
  function automatic logic covers(input vec_t v, input logic c, input oct_t o, input node_t n);
    if (c) return v[n[NODE_W-1:GRP_W]];
    return (n[NODE_W-1:LOC_W] == o) && v[n[LOC_W-1:0]];
  endfunction
endpackage

// File: rtl/shv_encode.sv
module shv_encode
  import shv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  vec_t cur_vec,
  input  logic cur_coarse,
  input  oct_t cur_oct,
  input  node_t add_node,
  output vec_t nxt_vec,
  output logic nxt_coarse,
  output oct_t nxt_oct
);
  oct_t add_oct;
  logic empty_exact;
  logic spill;

  assign add_oct     = add_node[NODE_W-1:LOC_W];
  assign empty_exact = !cur_coarse && (cur_vec == '0);
  assign spill       = !cur_coarse && !empty_exact && (add_oct != cur_oct);

  always_comb begin
    nxt_vec    = cur_vec;
    nxt_coarse = cur_coarse;
    nxt_oct    = cur_oct;
    if (cur_coarse) begin
      nxt_vec[add_node[NODE_W-1:GRP_W]] = 1'b1;
    end else if (empty_exact) begin
      nxt_vec = '0;
      nxt_vec[add_node[LOC_W-1:0]] = 1'b1;
      nxt_oct = add_oct;
    end else if (!spill) begin
      nxt_vec[add_node[LOC_W-1:0]] = 1'b1;
    end else begin
      nxt_vec = fold_coarse(cur_vec, cur_oct);
      nxt_vec[add_node[NODE_W-1:GRP_W]] = 1'b1;
      nxt_coarse = 1'b1;
    end
  end

  // the new sharer is always represented (R1, R2, R3, R4)
  p_added_covered_r1: assert property (@(posedge clk) disable iff (!rst_n)
    covers(nxt_vec, nxt_coarse, nxt_oct, add_node));
  // on a spill the lowest old sharer survives in the coarse field
  p_no_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spill |-> (nxt_coarse && covers(nxt_vec, 1'b1, nxt_oct, {cur_oct, low_idx(cur_vec)})));
  // coarse never reverts to exact
  p_coarse_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_coarse |-> (nxt_coarse && ((cur_vec & ~nxt_vec) == '0)));
endmodule

// File: rtl/shv_width.sv
module shv_width
  import shv_pkg::*;
#(
  parameter int NAR_W = 16
) (
  input  logic [NAR_W-1:0] entry_in,
  output vec_t             wide_vec,
  output logic             wide_coarse,
  output oct_t             wide_oct,
  input  vec_t             int_vec,
  output logic [NAR_W-1:0] entry_out
);
  localparam int PAD_W = VEC_W - NAR_W;

  assign wide_vec    = {{PAD_W{1'b0}}, entry_in};
  assign wide_coarse = 1'b0;
  assign wide_oct    = '0;
  assign entry_out   = int_vec[NAR_W-1:0];
endmodule

// File: rtl/shv_unicast.sv
module shv_unicast
  import shv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  vec_t  in_vec,
  input  logic  in_coarse,
  input  oct_t  in_oct,
  output logic  busy,
  output logic  valid,
  output node_t node,
  output logic  done
);
  vec_t work_q;
  logic md_coarse_q;
  oct_t oct_q;
  sub_t sub_q;

  logic accept;
  idx_t cur_idx;
  logic step_clear;
  vec_t rest;
  logic finishing;

  assign accept     = start && !busy;
  assign cur_idx    = low_idx(work_q);
  assign step_clear = md_coarse_q ? (sub_q == sub_t'((1 << GRP_W) - 1)) : 1'b1;
  assign rest       = work_q & ~(vec_t'(1) << cur_idx);
  assign finishing  = busy && step_clear && (rest == '0);
  assign valid      = busy;
  assign node       = md_coarse_q ? {cur_idx, sub_q} : {oct_q, cur_idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      work_q      <= '0;
      md_coarse_q <= 1'b0;
      oct_q       <= '0;
      sub_q       <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        work_q      <= in_vec;
        md_coarse_q <= in_coarse;
        oct_q       <= in_oct;
        sub_q       <= '0;
        if (in_vec == '0) done <= 1'b1;
        else              busy <= 1'b1;
      end else if (busy) begin
        if (step_clear) begin
          work_q <= rest;
          sub_q  <= '0;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
        if (finishing) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> !done);
  p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (node > $past(node)));
  p_hold_job_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(oct_q) && $stable(md_coarse_q)));
  p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_vec == '0)) |=> (done && !busy));
endmodule

// File: rtl/sharer_vec_codec.sv
module sharer_vec_codec
  import shv_pkg::*;
#(
  parameter int NAR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  enc_vec_i,
  input  logic              enc_coarse_i,
  input  logic [OCT_W-1:0]  enc_oct_i,
  input  logic [NODE_W-1:0] enc_node_i,
  output logic [VEC_W-1:0]  enc_vec_o,
  output logic              enc_coarse_o,
  output logic [OCT_W-1:0]  enc_oct_o,
  input  logic [NAR_W-1:0]  nar_entry_i,
  output logic [VEC_W-1:0]  wide_vec_o,
  output logic              wide_coarse_o,
  output logic [OCT_W-1:0]  wide_oct_o,
  input  logic [VEC_W-1:0]  wide_vec_i,
  output logic [NAR_W-1:0]  nar_entry_o,
  input  logic              inv_start_i,
  input  logic [VEC_W-1:0]  inv_vec_i,
  input  logic              inv_coarse_i,
  input  logic [OCT_W-1:0]  inv_oct_i,
  output logic              inv_busy_o,
  output logic              inv_valid_o,
  output logic [NODE_W-1:0] inv_node_o,
  output logic              inv_done_o
);
  shv_encode u_enc (
    .clk(clk), .rst_n(rst_n),
    .cur_vec(enc_vec_i), .cur_coarse(enc_coarse_i), .cur_oct(enc_oct_i),
    .add_node(enc_node_i),
    .nxt_vec(enc_vec_o), .nxt_coarse(enc_coarse_o), .nxt_oct(enc_oct_o)
  );

  shv_width #(.NAR_W(NAR_W)) u_wid (
    .entry_in(nar_entry_i), .wide_vec(wide_vec_o), .wide_coarse(wide_coarse_o),
    .wide_oct(wide_oct_o), .int_vec(wide_vec_i), .entry_out(nar_entry_o)
  );

  shv_unicast u_uni (
    .clk(clk), .rst_n(rst_n), .start(inv_start_i),
    .in_vec(inv_vec_i), .in_coarse(inv_coarse_i), .in_oct(inv_oct_i),
    .busy(inv_busy_o), .valid(inv_valid_o), .node(inv_node_o), .done(inv_done_o)
  );

  // reset leaves the expander silent (R11)
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_n |=> (!inv_busy_o && !inv_done_o));
endmodule

// File: tb/tb_sharer_vec_codec.sv
module tb_sharer_vec_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] enc_vec_i = '0;
  logic enc_coarse_i = 1'b0;
  logic [2:0] enc_oct_i = '0;
  logic [8:0] enc_node_i = '0;
  logic [63:0] enc_vec_o;
  logic enc_coarse_o;
  logic [2:0] enc_oct_o;
  logic [15:0] nar_entry_i = '0;
  logic [63:0] wide_vec_o;
  logic wide_coarse_o;
  logic [2:0] wide_oct_o;
  logic [63:0] wide_vec_i = '0;
  logic [15:0] nar_entry_o;
  logic inv_start_i = 1'b0;
  logic [63:0] inv_vec_i = '0;
  logic inv_coarse_i = 1'b0;
  logic [2:0] inv_oct_i = '0;
  logic inv_busy_o, inv_valid_o, inv_done_o;
  logic [8:0] inv_node_o;

  int total = 0;
  int bad = 0;
  int exp_ids [512];
  int exp_cnt;

  always #5 clk = ~clk;

  sharer_vec_codec dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit member(logic [63:0] v, bit c, logic [2:0] o, int n);
    if (c) return v[n / 8];
    return (int'(o) == n / 64) && v[n % 64];
  endfunction

  // reference add: collect the node set, add, then choose the layout
  task automatic check_enc(input logic [63:0] v, input bit c, input logic [2:0] o,
                           input int n, input string tag);
    bit inset [512];
    int first_oct = -1;
    bit mixed = 0;
    logic [63:0] ev = '0;
    bit ec;
    logic [2:0] eo;
    for (int k = 0; k < 512; k++) inset[k] = member(v, c, o, k);
    inset[n] = 1;
    for (int k = 0; k < 512; k++)
      if (inset[k]) begin
        if (first_oct < 0) first_oct = k / 64;
        else if (first_oct != k / 64) mixed = 1;
      end
    ec = c || mixed;
    eo = ec ? o : 3'(first_oct);
    for (int k = 0; k < 512; k++)
      if (inset[k]) begin
        if (ec) ev[k / 8] = 1'b1;
        else    ev[k % 64] = 1'b1;
      end
    enc_vec_i = v; enc_coarse_i = c; enc_oct_i = o; enc_node_i = 9'(n);
    #1;
    chk(enc_vec_o == ev, {tag, " vec"}, enc_vec_o, ev);
    chk(enc_coarse_o == ec, {tag, " fmt"}, 64'(enc_coarse_o), 64'(ec));
    if (!ec) chk(enc_oct_o == eo, {tag, " oct"}, 64'(enc_oct_o), 64'(eo));
  endtask

  task automatic run_dec(input logic [63:0] v, input bit c, input logic [2:0] o,
                         input bit inject, input string tag);
    exp_cnt = 0;
    for (int k = 0; k < 512; k++)
      if (member(v, c, o, k)) begin exp_ids[exp_cnt] = k; exp_cnt++; end
    @(negedge clk);
    inv_vec_i = v; inv_coarse_i = c; inv_oct_i = o; inv_start_i = 1'b1;
    @(negedge clk);
    inv_start_i = 1'b0;
    if (exp_cnt == 0) begin
      chk(inv_done_o && !inv_valid_o && !inv_busy_o, {tag, " R9 empty done"},
          {61'b0, inv_done_o, inv_valid_o, inv_busy_o}, 64'h4);
      @(negedge clk);
      chk(!inv_done_o && !inv_valid_o, {tag, " R9 quiet after"}, 64'(inv_done_o), 64'h0);
    end else begin
      chk(inv_busy_o, {tag, " R8 busy"}, 64'(inv_busy_o), 64'h1);
      for (int k = 0; k < exp_cnt; k++) begin
        chk(inv_valid_o && int'(inv_node_o) == exp_ids[k], {tag, " id"},
            64'(inv_node_o), 64'(exp_ids[k]));
        if (inject && k == 1) begin
          inv_start_i = 1'b1; inv_vec_i = 64'h8000_0000_0000_0001; inv_coarse_i = ~c;
          inv_oct_i = o + 3'd1;
        end else begin
          inv_start_i = 1'b0;
        end
        @(negedge clk);
      end
      inv_start_i = 1'b0;
      chk(inv_done_o && !inv_busy_o && !inv_valid_o, {tag, " R8 done pulse"},
          {61'b0, inv_done_o, inv_valid_o, inv_busy_o}, 64'h4);
      @(negedge clk);
      chk(!inv_done_o, {tag, " R8 done one cycle"}, 64'(inv_done_o), 64'h0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!inv_busy_o && !inv_valid_o && !inv_done_o, "R11 reset quiet",
        {61'b0, inv_done_o, inv_valid_o, inv_busy_o}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_encode;
    check_enc(64'h0000_0000_0000_0100, 0, 3'd5, 5 * 64 + 17, "R1 same octant");
    check_enc(64'h0, 0, 3'd2, 6 * 64 + 63, "R2 empty exact");
    check_enc(64'h0000_0000_0010_0020, 0, 3'd2, 300, "R3 spill");
    check_enc(64'h8000_0000_0000_0001, 0, 3'd7, 3, "R3 spill wide");
    check_enc(64'h0000_0001_0000_0000, 1, 3'd0, 511, "R4 coarse add");
    check_enc(64'h0000_0001_0000_0000, 1, 3'd0, 259, "R4 coarse same group");
  endtask

  task automatic t_width;
    nar_entry_i = 16'hA5C3; wide_vec_i = 64'hFFFF_0000_1234_BEEF;
    #1;
    chk(wide_vec_o == 64'h0000_0000_0000_A5C3 && !wide_coarse_o && wide_oct_o == 3'd0,
        "R5 widen", wide_vec_o, 64'hA5C3);
    chk(nar_entry_o == 16'hBEEF, "R5 narrow", 64'(nar_entry_o), 64'hBEEF);
  endtask

  task automatic t_decode;
    run_dec(64'h8000_0000_0000_0081, 0, 3'd3, 0, "R6 exact");
    run_dec(64'h0F00_0000_0000_F000, 0, 3'd6, 1, "R10 start ignored");
    run_dec(64'h8000_0000_0000_0001, 1, 3'd0, 0, "R7 coarse");
    run_dec(64'h0, 0, 3'd1, 0, "R9 empty");
    run_dec(64'h0000_0000_0000_0300, 1, 3'd4, 1, "R7 R10 coarse inject");
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_encode();
    t_width();
    t_decode();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule